// File: doc/BRIEF.md
# Memory-Mapped Keyboard and Display Terminal

This block puts a character terminal on a simple word-wide processor bus. Four word registers sit at fixed addresses. Two belong to the receive side, which takes keyboard characters, and two belong to the transmit side, which sends characters to a display. The processor finds out whether a character is waiting, or whether the display can take another one, by reading a Ready bit on each side. It can also set an enable bit per side so that a Ready bit raises a level interrupt.

The keyboard side is a valid-only stream with no back-pressure. A character offered on `kb_valid` is always taken in the same cycle, and it overwrites any character that has not been read. That loss is recorded in a sticky overrun flag.

The display side is a valid/ready stream. Once a character has been accepted from the bus, `disp_valid` stays high and `disp_data` stays stable until the display raises `disp_ready`. The display holds `disp_ready` low for as long as it is still consuming the character. The transfer completes on the cycle where `disp_valid` and `disp_ready` are both high. During that whole window the transmit Ready bit reads 0.

Top module: `term_mmio`

## Requirements
- R1: Registers decode from `BASE_ADDR` (default 0xFFFF0000) using address bits [3:2]: receive control at +0x0, receive data at +0x4, transmit control at +0x8, transmit data at +0xC. Address bits [1:0] are ignored. Reads of any other address return 0, and writes to any other address change nothing.
- R2: In both control registers, bit 0 is Ready and bit 1 is Interrupt Enable. Receive control also has bit 2 as Overrun. All other bits read 0. A write updates only the Interrupt Enable bit, from `bus_wdata[1]`; Ready bits are read-only.
- R3: A read of receive data returns the held character and clears receive Ready on the next cycle. If a keyboard character arrives in the same cycle as that read, Ready stays 1, the new character replaces the old one, and no overrun is recorded.
- R4: A cycle with `kb_valid` high latches `kb_data` into receive data bits [7:0] and sets receive Ready, both visible on the next cycle. The upper bits of receive data read 0, and writes to receive data are ignored.
- R5: A keyboard character that arrives while receive Ready is 1, with no read of receive data in that cycle, sets Overrun. Overrun stays set until receive control is read; that read returns 1 and clears it on the next cycle.
- R6: A write to transmit data while transmit Ready is 1 puts `bus_wdata[7:0]` on `disp_data`. From the next cycle, `disp_valid` is 1 and transmit Ready reads 0.
- R7: While `disp_valid` is 1 and `disp_ready` is 0, `disp_data` holds its value. The cycle after `disp_valid` and `disp_ready` are both 1, `disp_valid` is 0 and transmit Ready reads 1.
- R8: A write to transmit data while transmit Ready is 0 is ignored: the character on the display stream does not change.
- R9: `irq` is 1 exactly when (receive Enable and receive Ready) or (transmit Enable and transmit Ready).
- R10: After reset, receive control reads 0, receive data reads 0, transmit control reads 1 (Ready set, Enable clear), `disp_valid` is 0 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data; combinational in the access cycle, 0 when not reading |
| kb_valid | input | 1 | Keyboard character strobe; always accepted |
| kb_data | input | CHAR_W | Keyboard character |
| disp_valid | output | 1 | Character offered to the display |
| disp_data | output | CHAR_W | Character to the display |
| disp_ready | input | 1 | Display has consumed the offered character |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with its default parameters: a base address of 0xFFFF0000, 32-bit bus words and 8-bit characters. With these values it can aim at the four registers and also at the words just outside them. It can reach each register through addresses whose two low bits are not zero. It can put values wider than a character on the bus, so the byte truncation can be checked. The fixed base also lets a behavioural model drive long random runs in which keyboard strobes collide with data reads, overruns occur, and display stalls overlap with writes made while the display is busy.

// File: rtl/term_pkg.sv
package term_pkg;
  localparam int NUM_REGS = 4;
  localparam int IDX_W    = $clog2(NUM_REGS);
  localparam int BYTE_LSB = 2;

  localparam int BIT_RDY = 0;
  localparam int BIT_IE  = 1;
  localparam int BIT_OVR = 2;

  typedef enum logic [IDX_W-1:0] {
    REG_RXCTL = 2'd0,
    REG_RXDAT = 2'd1,
    REG_TXCTL = 2'd2,
    REG_TXDAT = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic rd_en;
    logic rd_rxctl;
    logic rd_rxdat;
    logic wr_rxctl;
    logic wr_txctl;
    logic wr_txdat;
  } acc_t;
endpackage

// File: rtl/term_decode.sv
module term_decode
  import term_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'hFFFF_0000
) (
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  output reg_sel_e          idx,
  output acc_t              acc
);
  localparam int TAG_LSB = IDX_W + BYTE_LSB;

  logic hit;
  logic [NUM_REGS-1:0] rd_hot;
  logic [NUM_REGS-1:0] wr_hot;
  logic unused_low;

  assign unused_low = &{1'b0, bus_addr[BYTE_LSB-1:0]};
  assign hit = bus_sel && (bus_addr[ADDR_W-1:TAG_LSB] == BASE_ADDR[ADDR_W-1:TAG_LSB]);
  assign idx = reg_sel_e'(bus_addr[TAG_LSB-1:BYTE_LSB]);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_hot
    assign rd_hot[g] = hit && !bus_we && (idx == reg_sel_e'(g));
    assign wr_hot[g] = hit &&  bus_we && (idx == reg_sel_e'(g));
  end

  assign acc.rd_en    = hit && !bus_we;
  assign acc.rd_rxctl = rd_hot[REG_RXCTL];
  assign acc.rd_rxdat = rd_hot[REG_RXDAT];
  assign acc.wr_rxctl = wr_hot[REG_RXCTL];
  assign acc.wr_txctl = wr_hot[REG_TXCTL];
  assign acc.wr_txdat = wr_hot[REG_TXDAT];

  logic unused_hot;
  assign unused_hot = &{1'b0, rd_hot[REG_TXCTL], rd_hot[REG_TXDAT], wr_hot[REG_RXDAT]};
endmodule

// File: rtl/term_rx.sv
module term_rx #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              kb_valid,
  input  logic [CHAR_W-1:0] kb_data,
  input  logic              rd_dat,
  input  logic              rd_ctl,
  input  logic              wr_ctl,
  input  logic              wr_ie,
  output logic              rdy,
  output logic              ie,
  output logic              ovr,
  output logic [CHAR_W-1:0] chr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy <= 1'b0;
      ie  <= 1'b0;
      ovr <= 1'b0;
      chr <= '0;
    end else begin
      if (kb_valid) begin
        chr <= kb_data;
        rdy <= 1'b1;
      end else if (rd_dat) begin
        rdy <= 1'b0;
      end
      if (kb_valid && rdy && !rd_dat) ovr <= 1'b1;
      else if (rd_ctl)                ovr <= 1'b0;
      if (wr_ctl) ie <= wr_ie;
    end
  end
endmodule

// File: rtl/term_tx.sv
module term_tx #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctl,
  input  logic              wr_ie,
  input  logic              wr_dat,
  input  logic [CHAR_W-1:0] wr_chr,
  input  logic              disp_ready,
  output logic              busy,
  output logic              ie,
  output logic [CHAR_W-1:0] chr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      ie   <= 1'b0;
      chr  <= '0;
    end else begin
      if (busy) begin
        if (disp_ready) busy <= 1'b0;
      end else if (wr_dat) begin
        busy <= 1'b1;
        chr  <= wr_chr;
      end
      if (wr_ctl) ie <= wr_ie;
    end
  end
endmodule

// File: rtl/term_mmio.sv
module term_mmio
  import term_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CHAR_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'hFFFF_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              kb_valid,
  input  logic [CHAR_W-1:0] kb_data,
  output logic              disp_valid,
  output logic [CHAR_W-1:0] disp_data,
  input  logic              disp_ready,
  output logic              irq
);
  reg_sel_e          idx;
  acc_t              acc;
  logic              rx_rdy, rx_ie, rx_ovr;
  logic [CHAR_W-1:0] rx_chr;
  logic              tx_busy, tx_ie;
  logic              tx_rdy;

  term_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
    .bus_sel (bus_sel),
    .bus_we  (bus_we),
    .bus_addr(bus_addr),
    .idx     (idx),
    .acc     (acc)
  );

  term_rx #(.CHAR_W(CHAR_W)) u_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .kb_valid(kb_valid),
    .kb_data (kb_data),
    .rd_dat  (acc.rd_rxdat),
    .rd_ctl  (acc.rd_rxctl),
    .wr_ctl  (acc.wr_rxctl),
    .wr_ie   (bus_wdata[BIT_IE]),
    .rdy     (rx_rdy),
    .ie      (rx_ie),
    .ovr     (rx_ovr),
    .chr     (rx_chr)
  );

  term_tx #(.CHAR_W(CHAR_W)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_ctl    (acc.wr_txctl),
    .wr_ie     (bus_wdata[BIT_IE]),
    .wr_dat    (acc.wr_txdat),
    .wr_chr    (bus_wdata[CHAR_W-1:0]),
    .disp_ready(disp_ready),
    .busy      (tx_busy),
    .ie        (tx_ie),
    .chr       (disp_data)
  );

  assign tx_rdy     = !tx_busy;
  assign disp_valid = tx_busy;
  assign irq        = (rx_ie && rx_rdy) || (tx_ie && tx_rdy);

  always_comb begin
    bus_rdata = '0;
    if (acc.rd_en) begin
      unique case (idx)
        REG_RXCTL: begin
          bus_rdata[BIT_RDY] = rx_rdy;
          bus_rdata[BIT_IE]  = rx_ie;
          bus_rdata[BIT_OVR] = rx_ovr;
        end
        REG_RXDAT: bus_rdata[CHAR_W-1:0] = rx_chr;
        REG_TXCTL: begin
          bus_rdata[BIT_RDY] = tx_rdy;
          bus_rdata[BIT_IE]  = tx_ie;
        end
        default: bus_rdata = '0;
      endcase
    end
  end

  logic unused_wdata;
  assign unused_wdata = &{1'b0, bus_wdata};
endmodule

// File: rtl/term_mmio_chk.sv
module term_mmio_chk #(
  parameter int ADDR_W = 32,
  parameter int CHAR_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'hFFFF_0000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [CHAR_W-1:0] wchr,
  input logic              kb_valid,
  input logic [CHAR_W-1:0] kb_data,
  input logic              disp_valid,
  input logic [CHAR_W-1:0] disp_data,
  input logic              disp_ready,
  input logic              irq,
  input logic              rx_rdy,
  input logic              rx_ie,
  input logic              rx_ovr,
  input logic [CHAR_W-1:0] rx_chr,
  input logic              tx_ie
);
  logic in_win, rd_rxctl, rd_rxdat, wr_txdat;
  assign in_win   = bus_sel && (bus_addr[ADDR_W-1:4] == BASE_ADDR[ADDR_W-1:4]);
  assign rd_rxctl = in_win && !bus_we && (bus_addr[3:2] == 2'd0);
  assign rd_rxdat = in_win && !bus_we && (bus_addr[3:2] == 2'd1);
  assign wr_txdat = in_win &&  bus_we && (bus_addr[3:2] == 2'd3);

  a_r4_kb_capture: assert property (@(posedge clk) disable iff (!rst_n)
    kb_valid |=> rx_rdy && (rx_chr == $past(kb_data)));
  a_r3_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rxdat && !kb_valid) |=> !rx_rdy);
  a_r5_ovr_set: assert property (@(posedge clk) disable iff (!rst_n)
    (kb_valid && rx_rdy && !rd_rxdat) |=> rx_ovr);
  a_r5_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ovr && !rd_rxctl) |=> rx_ovr);
  a_r6_launch: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_txdat && !disp_valid) |=> disp_valid && (disp_data == $past(wchr)));
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && !disp_ready) |=> disp_valid && $stable(disp_data));
  a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && disp_ready) |=> !disp_valid);
  a_r9_irq_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (rx_ie || tx_ie));
endmodule

bind term_mmio term_mmio_chk #(
  .ADDR_W(ADDR_W), .CHAR_W(CHAR_W), .BASE_ADDR(BASE_ADDR)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .wchr      (bus_wdata[CHAR_W-1:0]),
  .kb_valid  (kb_valid),
  .kb_data   (kb_data),
  .disp_valid(disp_valid),
  .disp_data (disp_data),
  .disp_ready(disp_ready),
  .irq       (irq),
  .rx_rdy    (rx_rdy),
  .rx_ie     (rx_ie),
  .rx_ovr    (rx_ovr),
  .rx_chr    (rx_chr),
  .tx_ie     (tx_ie)
);

// File: tb/term_mmio_tb.sv
`timescale 1ns/1ps
module term_mmio_tb;
  localparam logic [31:0] RXC = 32'hFFFF_0000;
  localparam logic [31:0] RXD = 32'hFFFF_0004;
  localparam logic [31:0] TXC = 32'hFFFF_0008;
  localparam logic [31:0] TXD = 32'hFFFF_000C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [31:0] bus_addr = '0, bus_wdata = '0, bus_rdata;
  logic        kb_valid = 1'b0;
  logic [7:0]  kb_data = '0;
  logic        disp_valid, disp_ready = 1'b0, irq;
  logic [7:0]  disp_data;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  term_mmio u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .kb_valid(kb_valid), .kb_data(kb_data), .disp_valid(disp_valid),
    .disp_data(disp_data), .disp_ready(disp_ready), .irq(irq)
  );

  // behavioural reference state
  bit       m_rx_rdy, m_rx_ie, m_ovr, m_tx_ie, m_busy;
  bit [7:0] m_rx_chr, m_tx_chr;

  logic       b_hit;
  logic [1:0] b_idx;
  assign b_hit = bus_sel && (bus_addr[31:4] == 28'hFFFF000);
  assign b_idx = bus_addr[3:2];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rx_rdy = 0; m_rx_ie = 0; m_ovr = 0; m_tx_ie = 0; m_busy = 0;
      m_rx_chr = 0; m_tx_chr = 0;
    end else begin
      bit rdx, rdc, wr;
      rdx = b_hit && !bus_we && b_idx == 2'd1;
      rdc = b_hit && !bus_we && b_idx == 2'd0;
      wr  = b_hit && bus_we;
      if (kb_valid && m_rx_rdy && !rdx) m_ovr = 1;
      else if (rdc) m_ovr = 0;
      if (kb_valid) begin m_rx_chr = kb_data; m_rx_rdy = 1; end
      else if (rdx) m_rx_rdy = 0;
      if (wr && b_idx == 2'd0) m_rx_ie = bus_wdata[1];
      if (wr && b_idx == 2'd2) m_tx_ie = bus_wdata[1];
      if (m_busy) begin
        if (disp_ready) m_busy = 0;
      end else if (wr && b_idx == 2'd3) begin
        m_busy = 1; m_tx_chr = bus_wdata[7:0];
      end
    end
  end

  function automatic logic [31:0] exp_rdata();
    logic [31:0] v = '0;
    if (b_hit && !bus_we) begin
      case (b_idx)
        2'd0: v = {29'd0, m_ovr, m_rx_ie, m_rx_rdy};
        2'd1: v = {24'd0, m_rx_chr};
        2'd2: v = {30'd0, m_tx_ie, !m_busy};
        default: v = '0;
      endcase
    end
    return v;
  endfunction

  function automatic string addr_tag();
    if (!b_hit) return "R1";
    case (b_idx)
      2'd1: return "R4";
      2'd3: return "R1";
      default: return "R2";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    #1;
    if (!done) begin
      check("R9 irq", {31'd0, irq}, {31'd0, (m_rx_ie && m_rx_rdy) || (m_tx_ie && !m_busy)});
      check("R6/R7 disp_valid", {31'd0, disp_valid}, {31'd0, m_busy});
      if (m_busy) check("R6 disp_data", {24'd0, disp_data}, {24'd0, m_tx_chr});
      check(addr_tag(), bus_rdata, exp_rdata());
    end
  end

  task automatic step(input logic s, input logic w, input logic [31:0] a, input logic [31:0] d,
                      input logic kv, input logic [7:0] kd, input logic dr);
    @(negedge clk);
    bus_sel = s; bus_we = w; bus_addr = a; bus_wdata = d;
    kb_valid = kv; kb_data = kd; disp_ready = dr;
    #1;
  endtask

  task automatic idle(); step(0, 0, '0, '0, 0, '0, 0); endtask
  task automatic rd(input logic [31:0] a, input logic [31:0] exp, input string tag);
    step(1, 0, a, '0, 0, '0, 0);
    check(tag, bus_rdata, exp);
  endtask
  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    step(1, 1, a, d, 0, '0, 0);
  endtask
  task automatic kb(input logic [7:0] c); step(0, 0, '0, '0, 1, c, 0); endtask

  task automatic finish_run();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(4 * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10 reset values
    rd(RXC, 32'h0, "R10 rx ctrl");
    rd(RXD, 32'h0, "R10 rx data");
    rd(TXC, 32'h1, "R10 tx ctrl");
    rd(TXD, 32'h0, "R10 tx data");
    check("R10 irq", {31'd0, irq}, 32'd0);
    // R4 capture, R3 read clears
    kb(8'h41);
    rd(RXC, 32'h1, "R4 ready set");
    rd(RXD, 32'h41, "R4 char");
    rd(RXC, 32'h0, "R3 ready cleared");
    // R5 overrun
    kb(8'h42);
    kb(8'h43);
    rd(RXC, 32'h5, "R5 overrun set");
    rd(RXC, 32'h1, "R5 overrun cleared by read");
    rd(RXD, 32'h43, "R5 newest char kept");
    // R3 collision of read and arrival
    kb(8'h44);
    step(1, 0, RXD, '0, 1, 8'h45, 0);
    check("R3 read returns old", bus_rdata, 32'h44);
    rd(RXC, 32'h1, "R3 ready kept, no overrun");
    rd(RXD, 32'h45, "R3 new char");
    // R2 only IE writable; R9 rx interrupt
    wr(RXC, 32'hFFFF_FFFF);
    rd(RXC, 32'h2, "R2 ready/ovr not writable");
    kb(8'h10);
    idle();
    check("R9 rx irq high", {31'd0, irq}, 32'd1);
    rd(RXD, 32'h10, "R4 char");
    idle();
    check("R9 rx irq low", {31'd0, irq}, 32'd0);
    wr(RXC, 32'h0);
    // R6 transmit, R8 busy write ignored, R7 handshake
    wr(TXD, 32'h0000_015A);
    idle();
    check("R6 valid", {31'd0, disp_valid}, 32'd1);
    check("R6 data", {24'd0, disp_data}, 32'h5A);
    rd(TXC, 32'h0, "R6 ready low");
    wr(TXD, 32'h33);
    idle();
    check("R8 busy write ignored", {24'd0, disp_data}, 32'h5A);
    step(0, 0, '0, '0, 0, '0, 1);
    idle();
    check("R7 valid dropped", {31'd0, disp_valid}, 32'd0);
    rd(TXC, 32'h1, "R7 ready back");
    // R9 tx interrupt
    wr(TXC, 32'h2);
    idle();
    check("R9 tx irq high", {31'd0, irq}, 32'd1);
    wr(TXD, 32'h77);
    idle();
    check("R9 tx irq low while busy", {31'd0, irq}, 32'd0);
    step(0, 0, '0, '0, 0, '0, 1);
    idle();
    check("R9 tx irq back", {31'd0, irq}, 32'd1);
    wr(TXC, 32'h0);
    // R1 decoding
    rd(32'hFFFF_0010, 32'h0, "R1 beyond window");
    rd(32'h0000_0000, 32'h0, "R1 unmapped");
    wr(RXD, 32'hAA);
    wr(32'h0000_0008, 32'h2);
    rd(32'hFFFF_0006, 32'h10, "R1 low bits ignored");
    rd(TXC, 32'h1, "R1 unmapped write no effect");
    // random traffic, compared every cycle against the model
    for (int i = 0; i < 2000; i++) begin
      logic [31:0] a;
      case ($urandom_range(0, 5))
        0: a = RXC; 1: a = RXD; 2: a = TXC; 3: a = TXD;
        4: a = 32'hFFFF_0010 | $urandom_range(0, 3);
        default: a = RXD | 32'h3;
      endcase
      step($urandom_range(0, 1), $urandom_range(0, 1), a, $urandom,
           ($urandom_range(0, 9) < 3), 8'($urandom), $urandom_range(0, 1));
    end
    idle();
    finish_run();
  end
endmodule